// File: doc/BRIEF.md
# VLIW Fetch Packet Dispatcher

This block sits between the instruction fetch stage and the eight execution-unit slots of a very-long-instruction-word core. Each fetch packet is 256 bits wide and holds eight 32-bit instructions. The dispatcher splits it into one or more execute packets. The instructions within one execute packet are issued together in a single cycle. Successive execute packets go out in successive cycles. While execute packets of the current fetch packet are still waiting, the fetch side is held off.

A parallel flag in each instruction chains it to the instruction that follows it. A unit field in each instruction names the slot that receives it. The eight slots form two sets of four units: logic, shift/logic, multiply and data-address. When two instructions in one execute packet name the same slot, the first one in packet order is issued and the later one is dropped. An error strobe is raised alongside that issue. The block accepts the next fetch packet in the same cycle that it decides the final execute packet of the current one, so back-to-back fetch packets stream with no empty issue cycle.

Top module: `vliwDispatcher`

## Requirements
- R1: While reset is held and right after it, fetchReady is 1, every bit of slotValid is 0, slotInstr is all zero and conflictErr is 0.
- R2: Bit 0 of an instruction is its parallel flag. When it is 1, the instruction that follows in the fetch packet joins the same execute packet. When it is 0, the execute packet ends there. Instruction 7 (bits 255:224) always ends an execute packet, whatever its flag holds.
- R3: The target slot of an instruction is bit 28 × 4 + bits [30:29]. Slots 0 to 3 are the logic, shift/logic, multiply and data-address units of set 0, and slots 4 to 7 are the same units of set 1. An issued instruction appears unmodified on slotInstr[32*s+31 : 32*s], with slotValid[s] set.
- R4: Execute packets issue in fetch-packet order, one per cycle. If a fetch packet is accepted at clock edge E, its execute packet k is on the slot outputs for the cycle after edge E+1+k.
- R5: fetchReady is 0 while the held fetch packet still has an execute packet pending that is not its last. It is 1 when no fetch packet is held, or when the pending execute packet is the last one.
- R6: A fetch packet offered while the last execute packet of the previous one is pending is accepted at that same edge. Its first execute packet follows on the slot outputs in the very next cycle, with no empty cycle between the two.
- R7: If an instruction targets a slot already taken by an earlier instruction of the same execute packet, it is not issued. The earlier instruction keeps the slot, and conflictErr is 1 in the cycle that execute packet is on the outputs.
- R8: A fetch packet whose eight flags are all 0 issues as eight single-instruction execute packets. A packet in which all eight instructions chain, with eight distinct slots, issues as one execute packet with all eight slots valid.
- R9: In a cycle with no execute packet on the outputs, slotValid is all zero and conflictErr is 0. For every slot whose valid bit is 0, the slotInstr field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch packet is offered on fetchData |
| fetchData | input | 256 | Fetch packet; instruction i is bits 32*i+31 : 32*i |
| fetchReady | output | 1 | The dispatcher takes the offered fetch packet at this edge |
| slotValid | output | 8 | One bit per execution slot: an instruction is issued to it this cycle |
| slotInstr | output | 256 | Instruction for slot s on bits 32*s+31 : 32*s |
| conflictErr | output | 1 | The execute packet on the outputs lost an instruction to a slot clash |

## Verification
Two functions can fall in the same cycle: the decision of the final execute packet of one fetch packet, and the acceptance of the next fetch packet. The bench provokes this by offering a new fetch packet exactly in the cycle in which fetchReady rises for a two-packet predecessor. It then judges that the predecessor's second execute packet and the successor's single execute packet appear in adjacent cycles, each intact. A slot clash is also placed inside an execute packet that other instructions share. This checks that the error strobe coincides with that packet's issue, and that the first claimant keeps the slot.

// File: rtl/vliwDispPkg.sv
package vliwDispPkg;

  localparam int DEF_SLOTS   = 8;
  localparam int DEF_INSTR_W = 32;

  // field positions inside one instruction word
  localparam int PAR_BIT  = 0;
  localparam int SET_BIT  = 28;
  localparam int UNIT_LO  = 29;
  localparam int UNIT_HI  = 30;

  // control -> datapath strobes
  typedef struct packed {
    logic loadBuf;
    logic dispatch;
  } ctrlStrobe_t;

  function automatic logic [2:0] slotOf(input logic [DEF_INSTR_W-1:0] ins);
    return {ins[SET_BIT], ins[UNIT_HI:UNIT_LO]};
  endfunction

endpackage

// File: rtl/vliwDispCtrl.sv
module vliwDispCtrl
  import vliwDispPkg::*;
#(
  parameter int SLOTS = DEF_SLOTS,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic             isFinal,
  input  logic [IDX_W-1:0] nextStart,
  output logic             fetchReady,
  output logic [IDX_W-1:0] startPtr,
  output ctrlStrobe_t      strobe
);

  logic             bufValidQ;
  logic [IDX_W-1:0] startQ;
  logic             accept;

  // ready when empty, or when the pending execute packet is the last
  assign fetchReady = !bufValidQ || isFinal;
  assign accept     = fetchValid && fetchReady;

  always_comb begin
    strobe          = '0;
    strobe.loadBuf  = accept;
    strobe.dispatch = bufValidQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValidQ <= 1'b0;
      startQ    <= '0;
    end else if (accept) begin
      bufValidQ <= 1'b1;
      startQ    <= '0;
    end else if (bufValidQ) begin
      if (isFinal) bufValidQ <= 1'b0;
      else         startQ    <= nextStart;
    end
  end

  assign startPtr = startQ;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValidQ && !isFinal) |=> bufValidQ);

  // R4
  start_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValidQ && !isFinal) |=> (startQ > $past(startQ)));

  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (bufValidQ && startQ == '0));

endmodule

// File: rtl/vliwDispDatapath.sv
module vliwDispDatapath
  import vliwDispPkg::*;
#(
  parameter int SLOTS   = DEF_SLOTS,
  parameter int INSTR_W = DEF_INSTR_W,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int FP_W   = SLOTS * INSTR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [FP_W-1:0]    fetchData,
  input  logic [IDX_W-1:0]   startPtr,
  output logic               isFinal,
  output logic [IDX_W-1:0]   nextStart,
  output logic [SLOTS-1:0]   slotValid,
  output logic [FP_W-1:0]    slotInstr,
  output logic               conflictErr
);

  logic [FP_W-1:0]                bufQ;
  logic [SLOTS-1:0]               inPkt;
  logic [IDX_W-1:0]               endIdx;
  logic [SLOTS-1:0]               nxtValid;
  logic [SLOTS-1:0][INSTR_W-1:0]  nxtInstr;
  logic                           nxtConf;
  logic [SLOTS-1:0]               validQ;
  logic [SLOTS-1:0][INSTR_W-1:0]  instrQ;
  logic                           confQ;

  // fetch packet buffer
  always_ff @(posedge clk) begin
    if (!rstN)               bufQ <= '0;
    else if (strobe.loadBuf) bufQ <= fetchData;
  end

  // find the extent of the execute packet starting at startPtr
  always_comb begin
    logic inRun;
    inRun  = 1'b0;
    inPkt  = '0;
    endIdx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (IDX_W'(i) == startPtr) inRun = 1'b1;
      inPkt[i] = inRun;
      if (inRun) endIdx = IDX_W'(i);
      if (inRun && (!bufQ[i*INSTR_W + PAR_BIT] || i == SLOTS-1)) inRun = 1'b0;
    end
  end

  assign isFinal   = inPkt[SLOTS-1];
  assign nextStart = endIdx + 1'b1;

  // route members to their slots, first claimant wins
  always_comb begin
    logic [SLOTS-1:0]   used;
    logic [INSTR_W-1:0] ins;
    logic [2:0]         tgt;
    used     = '0;
    nxtValid = '0;
    nxtInstr = '0;
    nxtConf  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      ins = bufQ[i*INSTR_W +: INSTR_W];
      tgt = slotOf(ins);
      if (inPkt[i]) begin
        if (used[tgt]) begin
          nxtConf = 1'b1;
        end else begin
          used[tgt]     = 1'b1;
          nxtValid[tgt] = 1'b1;
          nxtInstr[tgt] = ins;
        end
      end
    end
  end

  // issue registers, cleared in idle cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      instrQ <= '0;
      confQ  <= 1'b0;
    end else if (strobe.dispatch) begin
      validQ <= nxtValid;
      instrQ <= nxtInstr;
      confQ  <= nxtConf;
    end else begin
      validQ <= '0;
      instrQ <= '0;
      confQ  <= 1'b0;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlotOut
    assign slotInstr[g*INSTR_W +: INSTR_W] = instrQ[g];
  end
  assign slotValid   = validQ;
  assign conflictErr = confQ;

  // R4
  dispatch_issues_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dispatch |=> (slotValid != '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid != '0) |-> $past(strobe.dispatch));

  // R7
  conflict_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictErr |-> ($past(strobe.dispatch) && slotValid != '0));

endmodule

// File: rtl/vliwDispatcher.sv
module vliwDispatcher
  import vliwDispPkg::*;
#(
  parameter int SLOTS   = DEF_SLOTS,
  parameter int INSTR_W = DEF_INSTR_W,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int FP_W   = SLOTS * INSTR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [FP_W-1:0]  fetchData,
  output logic             fetchReady,
  output logic [SLOTS-1:0] slotValid,
  output logic [FP_W-1:0]  slotInstr,
  output logic             conflictErr
);

  ctrlStrobe_t      strobe;
  logic             isFinal;
  logic [IDX_W-1:0] nextStart;
  logic [IDX_W-1:0] startPtr;

  vliwDispCtrl #(.SLOTS(SLOTS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .isFinal    (isFinal),
    .nextStart  (nextStart),
    .fetchReady (fetchReady),
    .startPtr   (startPtr),
    .strobe     (strobe)
  );

  vliwDispDatapath #(.SLOTS(SLOTS), .INSTR_W(INSTR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fetchData   (fetchData),
    .startPtr    (startPtr),
    .isFinal     (isFinal),
    .nextStart   (nextStart),
    .slotValid   (slotValid),
    .slotInstr   (slotInstr),
    .conflictErr (conflictErr)
  );

endmodule

// File: tb/tb_vliwDispatcher.sv
module tb_vliwDispatcher;

  logic         clk = 1'b0;
  logic         rstN;
  logic         fetchValid;
  logic [255:0] fetchData;
  logic         fetchReady;
  logic [7:0]   slotValid;
  logic [255:0] slotInstr;
  logic         conflictErr;

  int checks = 0;
  int errors = 0;

  logic [7:0]   expMask  [8];
  logic [255:0] expInstr [8];
  logic         expConf  [8];
  int           expN;

  always #5 clk = ~clk;

  vliwDispatcher dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchData(fetchData),
    .fetchReady(fetchReady), .slotValid(slotValid), .slotInstr(slotInstr),
    .conflictErr(conflictErr)
  );

  function automatic logic [31:0] mk(input int slot, input bit par, input int tag);
    logic [2:0]  s;
    logic [26:0] t;
    s = slot[2:0];
    t = tag[26:0];
    return {1'b0, s[1:0], s[2], t, par};
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected execute packets, built from R2, R3, R7
  task automatic buildModel(input logic [255:0] fp);
    logic [7:0]  used;
    logic [31:0] ins;
    logic [2:0]  s;
    int          p;
    for (int k = 0; k < 8; k++) begin
      expMask[k] = '0; expInstr[k] = '0; expConf[k] = 1'b0;
    end
    p = 0;
    used = '0;
    for (int i = 0; i < 8; i++) begin
      ins = fp[i*32 +: 32];
      s = {ins[28], ins[30:29]};
      if (used[s]) expConf[p] = 1'b1;
      else begin
        used[s] = 1'b1;
        expMask[p][s] = 1'b1;
        expInstr[p][s*32 +: 32] = ins;
      end
      if (!ins[0] || i == 7) begin
        p++;
        used = '0;
      end
    end
    expN = p;
  endtask

  task automatic idleCheck();
    chk("R9 idle slotValid", {248'b0, slotValid}, 256'b0);
    chk("R9 idle slotInstr", slotInstr, 256'b0);
    chk("R9 idle conflictErr", {255'b0, conflictErr}, 256'b0);
  endtask

  // offer one fetch packet and follow all its execute packets
  task automatic runFp(input logic [255:0] fp);
    buildModel(fp);
    @(negedge clk);
    chk("R5 ready when empty", {255'b0, fetchReady}, 256'b1);
    fetchValid = 1'b1;
    fetchData  = fp;
    for (int k = 0; k <= expN; k++) begin
      @(negedge clk);
      fetchValid = 1'b0;
      if (k < expN) chk("R5 ready vs pending", {255'b0, fetchReady}, {255'b0, (k == expN-1)});
      else          chk("R5 ready after drain", {255'b0, fetchReady}, 256'b1);
      if (k >= 1) begin
        chk("R4 slotValid per packet", {248'b0, slotValid}, {248'b0, expMask[k-1]});
        chk("R3 slotInstr routing", slotInstr, expInstr[k-1]);
        chk("R7 conflictErr", {255'b0, conflictErr}, {255'b0, expConf[k-1]});
      end else begin
        chk("R9 no issue before packet", {248'b0, slotValid}, 256'b0);
      end
    end
    @(negedge clk);
    idleCheck();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    fetchValid = 1'b0;
    fetchData = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset fetchReady", {255'b0, fetchReady}, 256'b1);
    chk("R1 reset slotValid", {248'b0, slotValid}, 256'b0);
    chk("R1 reset slotInstr", slotInstr, 256'b0);
    chk("R1 reset conflictErr", {255'b0, conflictErr}, 256'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset fetchReady", {255'b0, fetchReady}, 256'b1);
    idleCheck();
  endtask

  // R8, R2: all flags clear -> eight single packets
  task automatic testSerial();
    logic [255:0] fp;
    for (int i = 0; i < 8; i++) fp[i*32 +: 32] = mk(i, 1'b0, 100 + i);
    runFp(fp);
  endtask

  // R8, R2, R3: fully chained, instr 7 flag set but still closes, reversed slots
  task automatic testParallel();
    logic [255:0] fp;
    for (int i = 0; i < 8; i++) fp[i*32 +: 32] = mk(7 - i, 1'b1, 200 + i);
    runFp(fp);
    chk("R8 single packet count", 256'(expN), 256'd1);
  endtask

  // R2: mixed groups 3 / 1 / 4
  task automatic testMixed();
    logic [255:0] fp;
    fp[0*32 +: 32] = mk(5, 1'b1, 300);
    fp[1*32 +: 32] = mk(2, 1'b1, 301);
    fp[2*32 +: 32] = mk(6, 1'b0, 302);
    fp[3*32 +: 32] = mk(1, 1'b0, 303);
    fp[4*32 +: 32] = mk(0, 1'b1, 304);
    fp[5*32 +: 32] = mk(4, 1'b1, 305);
    fp[6*32 +: 32] = mk(3, 1'b1, 306);
    fp[7*32 +: 32] = mk(7, 1'b1, 307);
    runFp(fp);
    chk("R2 mixed packet count", 256'(expN), 256'd3);
  endtask

  // R7: clash on slot 2 inside a shared packet
  task automatic testConflict();
    logic [255:0] fp;
    fp[0*32 +: 32] = mk(2, 1'b1, 400);
    fp[1*32 +: 32] = mk(5, 1'b1, 401);
    fp[2*32 +: 32] = mk(2, 1'b0, 402);
    fp[3*32 +: 32] = mk(3, 1'b1, 403);
    fp[4*32 +: 32] = mk(3, 1'b0, 404);
    fp[5*32 +: 32] = mk(0, 1'b0, 405);
    fp[6*32 +: 32] = mk(6, 1'b1, 406);
    fp[7*32 +: 32] = mk(7, 1'b0, 407);
    runFp(fp);
    chk("R7 first claimant kept", 256'(expInstr[0][2*32 +: 32]), 256'(mk(2, 1'b1, 400)));
  endtask

  // R6: next fetch accepted with the final dispatch, no gap cycle
  task automatic testOverlap();
    logic [255:0] fpA, fpB;
    for (int i = 0; i < 8; i++) fpA[i*32 +: 32] = mk(i, (i != 3), 500 + i);
    for (int i = 0; i < 8; i++) fpB[i*32 +: 32] = mk(i, 1'b1, 600 + i);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchData  = fpA;
    @(negedge clk);
    fetchValid = 1'b0;
    chk("R5 stall with two packets", {255'b0, fetchReady}, 256'b0);
    @(negedge clk);
    chk("R6 ready on final packet", {255'b0, fetchReady}, 256'b1);
    chk("R4 first packet of A", {248'b0, slotValid}, 256'h0F);
    fetchValid = 1'b1;
    fetchData  = fpB;
    @(negedge clk);
    fetchValid = 1'b0;
    chk("R4 second packet of A", {248'b0, slotValid}, 256'hF0);
    chk("R3 second packet instr", slotInstr, {fpA[255:128], 128'b0});
    chk("R5 ready for single packet B", {255'b0, fetchReady}, 256'b1);
    @(negedge clk);
    chk("R6 B follows with no gap", {248'b0, slotValid}, 256'hFF);
    chk("R6 B instr", slotInstr, fpB);
    @(negedge clk);
    idleCheck();
  endtask

  bit done = 1'b0;

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testSerial();
    testParallel();
    testMixed();
    testConflict();
    testOverlap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule